// File: doc/BRIEF.md
# Indexed Codec Register Interface

This block is the host-facing register front end of an audio codec. The host sees four byte-wide ports, picked by a 2-bit port select. An index port chooses one register in a bank of indirect 8-bit control registers. A data port reads and writes that register. A status port carries the interrupt flag. The fourth port is a programmed-I/O data port, which this block leaves unused.

Most indirect registers only store what the host writes. A few of them have rules of their own:
- The sample-format register is protected by a mode-change enable flag that is held in the index port.
- A mode bit widens the index from 16 to 32 registers.
- Some registers are reserved or read-only.
- One register carries a calibration-in-progress flag that shows for a set number of reads.

The interrupt flag is set by a completion pulse from the playback datapath. The host can clear it in two ways. The block exports the format register, the playback enable bit, the interrupt line and the calibration flag.

Top module: `codec_regif`

## Requirements
- R1: After reset, the index port reads 0x40 and the status port reads 0. Indirect registers 2–5 and 18–19 read 0x88, registers 6–7 read 0x80, register 9 reads 0x08, register 12 reads 0x8A, and registers 25–26 read 0xA0. Every other indirect register reads 0.
- R2: Bit 7 of a write to the index port (port 0) is not stored, so the index port always reads bit 7 as 0. Bit 6 of the index port is the mode-change enable flag.
- R3: When bit 6 of register 12 is clear, the data port (port 1) uses the low 4 bits of the index. When that bit is set, it uses the low 5 bits.
- R4: When the mode-change enable flag is set, a write to register 8 replaces the whole register. The value of register 8 is driven on `fmtOut`.
- R5: When the mode-change enable flag is clear and bit 4 of register 24 is set, a write to register 8 updates only bits 7:4. When both are clear, the write has no effect.
- R6: Writes to registers 11, 22, 27 and 29 have no effect.
- R7: A write to register 12 changes only bit 6 of that register.
- R8: A write to register 9 always stores bit 5 as 0. Bit 0 of register 9 is driven on `playEn`.
- R9: Any write to the status port (port 2) clears the interrupt flag (status bit 0) and clears bits 6:4 of register 24. `irqOut` follows the interrupt flag.
- R10: A write to register 24 that takes bit 4 from 1 to 0 clears the interrupt flag. A write that leaves bit 4 at 1 keeps the flag.
- R11: The calibration counter is loaded with CAL_LOAD (default 1) when both of these hold:
  - an index-port write takes the mode-change enable flag from 0 to 1;
  - bit 3 or bit 4 of register 9 is set.
  While the counter is nonzero, a data-port read of register 11 returns bit 5 set and decrements the counter. `calBusy` is high while the counter is nonzero.
- R12: A pulse on `doneEvt` sets the interrupt flag and sets bit 4 of register 24. If the same cycle also holds a status-port write, the pulse wins.
- R13: A write to the PIO port (port 3) has no effect, and that port reads 0. Reads have no side effect, except the read of register 11 described in R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| portSel | input | 2 | Port select: 0 index, 1 data, 2 status, 3 PIO |
| wrEn | input | 1 | Write strobe for the selected port |
| rdEn | input | 1 | Read strobe for the selected port |
| wrData | input | 8 | Write byte |
| doneEvt | input | 1 | Playback completion pulse |
| rdData | output | 8 | Read byte for the selected port (combinational) |
| irqOut | output | 1 | Interrupt request |
| fmtOut | output | 8 | Current format register (register 8) |
| playEn | output | 1 | Playback enable (register 9 bit 0) |
| calBusy | output | 1 | Calibration counter nonzero |

## Verification
The hardest state to reach from the ports is the partial format update. It needs three things at once: the mode-change flag cleared, bit 4 of register 24 set, and register 24 reachable at all, which needs the extended index mode. The stimulus first enables extended mode through register 12, then sets bit 4 of register 24, then drops the mode-change flag with an index write before writing register 8. The calibration flag needs a 0-to-1 edge on the mode-change flag while register 9 holds bit 3 or 4. The bench therefore lowers the flag with one index write and raises it with the next, and it also repeats that edge with those bits cleared.

// File: rtl/codec_regif_pkg.sv
package codec_regif_pkg;
  localparam int IDX_W = 5;
  localparam int NREG = 1 << IDX_W;
  localparam int DW = 8;

  typedef enum logic [1:0] {
    PORT_IDX  = 2'd0,
    PORT_DATA = 2'd1,
    PORT_STAT = 2'd2,
    PORT_PIO  = 2'd3
  } portSel_e;

  localparam logic [IDX_W-1:0] REG_FMT   = 5'd8;
  localparam logic [IDX_W-1:0] REG_CFG   = 5'd9;
  localparam logic [IDX_W-1:0] REG_INIT  = 5'd11;
  localparam logic [IDX_W-1:0] REG_MODE  = 5'd12;
  localparam logic [IDX_W-1:0] REG_ALTST = 5'd24;

  typedef struct packed {
    logic             idxWr;
    logic             dataWr;
    logic             statWr;
    logic             fmtFull;
    logic             fmtUpper;
    logic             calHit;
    logic [IDX_W-1:0] idx;
  } strobe_t;

  function automatic logic [DW-1:0] resetVal(input logic [IDX_W-1:0] a);
    case (a)
      5'd2, 5'd3, 5'd4, 5'd5, 5'd18, 5'd19: resetVal = 8'h88;
      5'd6, 5'd7:                           resetVal = 8'h80;
      5'd9:                                 resetVal = 8'h08;
      5'd12:                                resetVal = 8'h8A;
      5'd25, 5'd26:                         resetVal = 8'hA0;
      default:                              resetVal = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/codec_regif_ctrl.sv
module codec_regif_ctrl
  import codec_regif_pkg::*;
#(
  parameter int CAL_LOAD = 1,
  localparam int CAL_W = (CAL_LOAD < 2) ? 1 : $clog2(CAL_LOAD + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    portSel,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [DW-1:0] wrData,
  input  logic          extMode,
  input  logic          cfgCalReq,
  input  logic          fmtUpperEn,
  output strobe_t       stb,
  output logic [6:0]    idxQ,
  output logic          calBusy
);
  logic [CAL_W-1:0] calCnt;
  logic [IDX_W-1:0] idxEff;
  logic             dataSel;
  logic             mceRise;

  assign idxEff  = extMode ? idxQ[IDX_W-1:0] : {1'b0, idxQ[3:0]};
  assign dataSel = (portSel == PORT_DATA);
  assign mceRise = !idxQ[6] && wrData[6];
  assign calBusy = (calCnt != '0);

  always_comb begin
    stb          = '0;
    stb.idx      = idxEff;
    stb.idxWr    = wrEn && (portSel == PORT_IDX);
    stb.dataWr   = wrEn && dataSel;
    stb.statWr   = wrEn && (portSel == PORT_STAT);
    stb.fmtFull  = stb.dataWr && (idxEff == REG_FMT) && idxQ[6];
    stb.fmtUpper = stb.dataWr && (idxEff == REG_FMT) && !idxQ[6] && fmtUpperEn;
    stb.calHit   = dataSel && (idxEff == REG_INIT) && calBusy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ   <= 7'h40;
      calCnt <= '0;
    end else begin
      if (stb.idxWr) begin
        idxQ <= wrData[6:0];
        if (mceRise && cfgCalReq) calCnt <= CAL_W'(CAL_LOAD);
      end else if (rdEn && stb.calHit) begin
        calCnt <= calCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/codec_regif_dp.sv
module codec_regif_dp
  import codec_regif_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [1:0]    portSel,
  input  logic [DW-1:0] wrData,
  input  logic [6:0]    idxQ,
  input  logic          doneEvt,
  output logic [DW-1:0] rdData,
  output logic [DW-1:0] fmtOut,
  output logic [DW-1:0] cfgOut,
  output logic          extMode,
  output logic          fmtUpperEn,
  output logic          intQ
);
  logic [DW-1:0] bank [NREG];
  logic          pendFall;

  assign fmtOut     = bank[REG_FMT];
  assign cfgOut     = bank[REG_CFG];
  assign extMode    = bank[REG_MODE][6];
  assign fmtUpperEn = bank[REG_ALTST][4];
  assign pendFall   = stb.dataWr && (stb.idx == REG_ALTST) &&
                      bank[REG_ALTST][4] && !wrData[4];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) bank[i] <= resetVal(IDX_W'(i));
    end else begin
      if (stb.dataWr) begin
        case (stb.idx)
          REG_FMT: begin
            if (stb.fmtFull)       bank[REG_FMT] <= wrData;
            else if (stb.fmtUpper) bank[REG_FMT] <= {wrData[7:4], bank[REG_FMT][3:0]};
          end
          REG_CFG:  bank[REG_CFG] <= wrData & 8'hDF;
          REG_MODE: bank[REG_MODE][6] <= wrData[6];
          REG_INIT, 5'd22, 5'd27, 5'd29: ;
          default:  bank[stb.idx] <= wrData;
        endcase
      end
      if (stb.statWr) bank[REG_ALTST][6:4] <= 3'b000;
      if (doneEvt)    bank[REG_ALTST][4] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                       intQ <= 1'b0;
    else if (doneEvt)                intQ <= 1'b1;
    else if (stb.statWr || pendFall) intQ <= 1'b0;
  end

  always_comb begin
    case (portSel)
      PORT_IDX:  rdData = {1'b0, idxQ};
      PORT_DATA: rdData = bank[stb.idx] | (stb.calHit ? 8'h20 : 8'h00);
      PORT_STAT: rdData = {7'b0, intQ};
      default:   rdData = 8'h00;
    endcase
  end
endmodule

// File: rtl/codec_regif.sv
module codec_regif
  import codec_regif_pkg::*;
#(
  parameter int CAL_LOAD = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] portSel,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] wrData,
  input  logic       doneEvt,
  output logic [7:0] rdData,
  output logic       irqOut,
  output logic [7:0] fmtOut,
  output logic       playEn,
  output logic       calBusy
);
  strobe_t       stb;
  logic [6:0]    idxQ;
  logic [DW-1:0] cfgOut;
  logic          extMode;
  logic          fmtUpperEn;

  codec_regif_ctrl #(.CAL_LOAD(CAL_LOAD)) u_ctrl (
    .clk(clk), .rstN(rstN), .portSel(portSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .extMode(extMode), .cfgCalReq(cfgOut[3] | cfgOut[4]),
    .fmtUpperEn(fmtUpperEn), .stb(stb), .idxQ(idxQ), .calBusy(calBusy)
  );

  codec_regif_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .portSel(portSel), .wrData(wrData),
    .idxQ(idxQ), .doneEvt(doneEvt), .rdData(rdData), .fmtOut(fmtOut),
    .cfgOut(cfgOut), .extMode(extMode), .fmtUpperEn(fmtUpperEn), .intQ(irqOut)
  );

  assign playEn = cfgOut[0];
endmodule

// File: rtl/codec_regif_chk.sv
module codec_regif_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] portSel,
  input logic       wrEn,
  input logic       rdEn,
  input logic [7:0] rdData,
  input logic       doneEvt,
  input logic       irqOut,
  input logic [7:0] fmtOut,
  input logic       calBusy
);
  a_r2_idx_bit7_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && portSel == 2'd0) |-> !rdData[7]);

  a_r4_fmt_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && portSel == 2'd1) |=> $stable(fmtOut));

  a_r9_status_clear: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && portSel == 2'd2 && !doneEvt) |=> !irqOut);

  a_r10_irq_fall_cause: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> $past(wrEn && (portSel == 2'd1 || portSel == 2'd2)));

  a_r11_cal_drop: assert property (@(posedge clk) disable iff (!rstN)
    $fell(calBusy) |-> $past(rdEn && portSel == 2'd1));

  a_r12_done_sets: assert property (@(posedge clk) disable iff (!rstN)
    doneEvt |=> irqOut);
endmodule

bind codec_regif codec_regif_chk u_chk (
  .clk(clk), .rstN(rstN), .portSel(portSel), .wrEn(wrEn), .rdEn(rdEn),
  .rdData(rdData), .doneEvt(doneEvt), .irqOut(irqOut), .fmtOut(fmtOut),
  .calBusy(calBusy)
);

// File: tb/tb_codec_regif.sv
module tb_codec_regif;
  logic       clk = 0;
  logic       rstN = 0;
  logic [1:0] portSel = 0;
  logic       wrEn = 0, rdEn = 0, doneEvt = 0;
  logic [7:0] wrData = 0;
  logic [7:0] rdData, fmtOut;
  logic       irqOut, playEn, calBusy;

  int nVec = 0, nBad = 0;
  bit finished = 0;

  int mIdx, mInt, mCal;
  int mReg [32];

  always #4 clk = ~clk;

  codec_regif dut (
    .clk(clk), .rstN(rstN), .portSel(portSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .doneEvt(doneEvt), .rdData(rdData), .irqOut(irqOut),
    .fmtOut(fmtOut), .playEn(playEn), .calBusy(calBusy)
  );

  function automatic int effIdx();
    return ((mReg[12] >> 6) & 1) ? (mIdx & 31) : (mIdx & 15);
  endfunction

  function automatic int expRead(int sel);
    int e;
    e = effIdx();
    case (sel)
      0: return mIdx & 8'h7F;
      1: return mReg[e] | ((e == 11 && mCal > 0) ? 32 : 0);
      2: return mInt;
      default: return 0;
    endcase
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 32; i++) mReg[i] = 0;
    for (int i = 2; i <= 5; i++) mReg[i] = 8'h88;
    mReg[18] = 8'h88; mReg[19] = 8'h88;
    mReg[6] = 8'h80; mReg[7] = 8'h80; mReg[9] = 8'h08; mReg[12] = 8'h8A;
    mReg[25] = 8'hA0; mReg[26] = 8'hA0;
    mIdx = 8'h40; mInt = 0; mCal = 0;
  endtask

  task automatic modelUpdate(int sel, bit wr, bit rd, int d, bit ev);
    int e;
    e = effIdx();
    if (wr && sel == 0) begin
      if (((mIdx & 8'h40) == 0) && ((d & 8'h40) != 0) && ((mReg[9] & 8'h18) != 0)) mCal = 1;
      mIdx = d & 8'h7F;
    end
    if (wr && sel == 1) begin
      if (e == 8) begin
        if (mIdx & 8'h40) mReg[8] = d;
        else if (mReg[24] & 8'h10) mReg[8] = (d & 8'hF0) | (mReg[8] & 8'h0F);
      end else if (e == 9) mReg[9] = d & 8'hDF;
      else if (e == 12) mReg[12] = (mReg[12] & 8'hBF) | (d & 8'h40);
      else if (e == 24) begin
        if ((mReg[24] & 8'h10) && !(d & 8'h10)) mInt = 0;
        mReg[24] = d;
      end else if (e != 11 && e != 22 && e != 27 && e != 29) mReg[e] = d;
    end
    if (wr && sel == 2) begin
      mInt = 0;
      mReg[24] = mReg[24] & 8'h8F;
    end
    if (rd && sel == 1 && e == 11 && mCal > 0) mCal = mCal - 1;
    if (ev) begin
      mInt = 1;
      mReg[24] = mReg[24] | 8'h10;
    end
  endtask

  task automatic step(string tag, int sel, bit wr, bit rd, int d, bit ev = 0);
    logic [19:0] act, exp;
    @(negedge clk);
    portSel = sel[1:0]; wrEn = wr; rdEn = rd; wrData = d[7:0]; doneEvt = ev;
    #1;
    act = {rd ? rdData : 8'h00, irqOut, fmtOut, playEn, calBusy, 1'b0};
    exp = {rd ? 8'(expRead(sel)) : 8'h00, 1'(mInt), 8'(mReg[8]),
           1'(mReg[9] & 1), (mCal > 0), 1'b0};
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
    modelUpdate(sel, wr, rd, d, ev);
  endtask

  task automatic wrI(string t, int v); step(t, 0, 1, 0, v); endtask
  task automatic wrD(string t, int v); step(t, 1, 1, 0, v); endtask
  task automatic rdP(string t, int s); step(t, s, 0, 1, 0); endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    rdP("R1 index reset", 0);
    rdP("R1 status reset", 2);
    for (int i = 0; i < 16; i++) begin wrI("R1", 8'h40 | i); rdP("R1 low bank", 1); end
    wrI("R7", 8'h4C); wrD("R7 mode write", 8'h40); rdP("R7 only bit6", 1);
    for (int i = 16; i < 32; i++) begin wrI("R3", 8'h40 | i); rdP("R1 R3 high bank", 1); end
    wrI("R2", 8'hB8); rdP("R2 bit7 dropped", 0); rdP("R3 wide mask", 1);
    wrI("R7", 8'h4C); wrD("R7 mode off", 8'h00); rdP("R7", 1);
    wrI("R3", 8'h38); rdP("R3 narrow mask", 1);
    wrI("R4", 8'h48); wrD("R4 full write", 8'h5B); rdP("R4 fmt", 1);
    wrI("R5", 8'h08); wrD("R5 ignored", 8'hA7); rdP("R5 unchanged", 1);
    wrI("R3", 8'h0C); wrD("R3 ext on", 8'h40);
    wrI("R5", 8'h18); wrD("R5 enable upper", 8'h10);
    wrI("R5", 8'h08); wrD("R5 upper nibble", 8'hA7); rdP("R5 merged", 1);
    wrI("R6", 8'h16); wrD("R6", 8'hFF); rdP("R6 reg22", 1);
    wrI("R6", 8'h1B); wrD("R6", 8'hFF); rdP("R6 reg27", 1);
    wrI("R6", 8'h1D); wrD("R6", 8'hFF); rdP("R6 reg29", 1);
    wrI("R6", 8'h0B); wrD("R6", 8'hFF); rdP("R6 reg11", 1);
    wrI("R8", 8'h09); wrD("R8", 8'hFF); rdP("R8 bit5 clear", 1);
    wrI("R8", 8'h0E); wrD("R8 plain reg", 8'h3C); rdP("R8 plain readback", 1);
    step("R12 done", 1, 0, 0, 0, 1); rdP("R12 status", 2);
    wrI("R12", 8'h18); rdP("R12 alt bit4", 1);
    step("R9 status write", 2, 1, 0, 8'hFF); rdP("R9 status", 2); rdP("R9 alt cleared", 1);
    step("R12 done again", 2, 0, 0, 0, 1);
    wrD("R10 keep bit4", 8'h30); rdP("R10 int held", 2);
    wrD("R10 drop bit4", 8'h20); rdP("R10 int cleared", 2);
    step("R12 done vs status", 2, 1, 0, 0, 1); rdP("R12 event wins", 2);
    step("R9", 2, 1, 0, 0);
    step("R13 pio write", 3, 1, 0, 8'h55); rdP("R13 pio read", 3);
    rdP("R13 status reread", 2); rdP("R13 data reread", 1); rdP("R13 data reread", 1);
    wrI("R11", 8'h0B); wrI("R11 rise", 8'h4B);
    rdP("R11 cal read", 1); rdP("R11 cal done", 1);
    wrI("R11", 8'h09); wrD("R11 cfg", 8'h01);
    wrI("R11", 8'h0B); wrI("R11 no load", 8'h4B); rdP("R11 no flag", 1);
    wrI("R11", 8'h09); wrD("R11 cfg", 8'h10);
    wrI("R11", 8'h0B); wrI("R11 rise bit4", 8'h4B);
    rdP("R11 peek status", 2); rdP("R11 flag bit4", 1); rdP("R11 cleared", 1);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule